// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block turns the synchronised input levels of a GPIO bank into one interrupt line. Each line has a 3-bit event code, taken from that line's configuration word. The code picks one of five event kinds: a falling edge, a rising edge, either edge, a low level or a high level. When a line's chosen event occurs, the line's bit in a status register is set. The status register clears when it is read, so software needs no acknowledge step.

A mask decides which status bits can raise the interrupt. Software turns mask bits on with a set-style write and turns them off with a clear-style write, and it can read the mask back. The interrupt output is high whenever any status bit is set together with its mask bit. A status bit latches whether or not its line is masked.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, the mask and status registers are zero and `irq` is low. The edge detector's previous-level register loads the current input during reset, so leaving reset with steady inputs produces no event.
- R2: Event code 0 sets a line's status bit on the clock edge after the line goes from 1 to 0.
- R3: Event code 1 sets a line's status bit on the clock edge after the line goes from 0 to 1. A 1 to 0 change sets nothing.
- R4: Event code 2 sets a line's status bit on a change in either direction.
- R5: Event code 3 sets a line's status bit on every clock edge at which the input is 0. A read made while the level persists is followed at once by a newly set bit.
- R6: Event code 4 sets a line's status bit on every clock edge at which the input is 1.
- R7: Event codes 5, 6 and 7 never set a status bit, whatever the input does.
- R8: A write to offset 0x20 sets the mask bits that are 1 in the write data. All other mask bits keep their values.
- R9: A write to offset 0x24 clears the mask bits that are 1 in the write data.
- R10: A read at offset 0x28 returns the mask on `bus_rdata` in the cycle after the read strobe. A read at any address other than 0x28 or 0x2C returns zero.
- R11: A read at offset 0x2C returns the latched status and then clears it. Status bits latch on unmasked lines as well as masked ones, and they stay set until a status read.
- R12: An event detected in the same cycle as a status read is not returned by that read. It stays latched and is returned by the next status read.
- R13: `irq` is high exactly when some status bit and the matching mask bit are both 1. It follows the registers with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | LINES | Synchronised pin levels |
| evt_sel | input | 3*LINES | Event code per line; line n uses bits [3n+2:3n] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Bank interrupt request |

## Verification
A pin change applied before clock edge k shows up in the status register, and therefore in `irq`, right after edge k. Mask writes take effect at the edge that samples the write strobe. Read data is registered, so it is due one cycle after the read strobe.

The bench drives all inputs on falling edges. A monitor pops each expected read value on the falling edge that follows the read's sampling edge. Checks of `irq` are made on the falling edge after the edge that changed a register.

The same-cycle case is covered by a pin edge applied together with a status read. The bench expects that read to return zero and the following read to return the event.

// File: rtl/gpio_irq_pkg.sv
// Package: shared event codes and register offsets for the GPIO bank
// interrupt detector. Assumes byte offsets compared on the low address bits.
package gpio_irq_pkg;
    localparam int EVT_W = 3;

    localparam logic [EVT_W-1:0] EV_FALL = 3'd0;
    localparam logic [EVT_W-1:0] EV_RISE = 3'd1;
    localparam logic [EVT_W-1:0] EV_BOTH = 3'd2;
    localparam logic [EVT_W-1:0] EV_LOW  = 3'd3;
    localparam logic [EVT_W-1:0] EV_HIGH = 3'd4;

    localparam logic [7:0] OFF_MASK_SET = 8'h20;
    localparam logic [7:0] OFF_MASK_CLR = 8'h24;
    localparam logic [7:0] OFF_MASK_RD  = 8'h28;
    localparam logic [7:0] OFF_STATUS   = 8'h2C;
endpackage

// File: rtl/gpio_evt_detect.sv
// gpio_evt_detect: per-line edge/level event decoder.
// Assumes lvl is already synchronised to clk. Produces a one-cycle-wide
// hit per line per detected event (levels hit every cycle they hold).
module gpio_evt_detect
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LINES-1:0]       lvl,
    input  logic [LINES*EVT_W-1:0] sel,
    output logic [LINES-1:0]       hit
);
    logic [LINES-1:0] prev_q;

    // Previous-level capture; reset loads the live level so no edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= lvl;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [EVT_W-1:0] code;
        assign code = sel[g*EVT_W +: EVT_W];

        // Decode the selected event kind against current and previous level.
        always_comb begin
            unique case (code)
                EV_FALL: hit[g] = prev_q[g] & ~lvl[g];
                EV_RISE: hit[g] = ~prev_q[g] & lvl[g];
                EV_BOTH: hit[g] = prev_q[g] ^ lvl[g];
                EV_LOW:  hit[g] = ~lvl[g];
                EV_HIGH: hit[g] = lvl[g];
                default: hit[g] = 1'b0;
            endcase
        end

        // R7
        reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code > EV_HIGH) |-> !hit[g]);
    end
endmodule

// File: rtl/gpio_irq_mask.sv
// gpio_irq_mask: interrupt mask register with set-by-write and
// clear-by-write ports. Assumes set_en and clr_en are never both high.
module gpio_irq_mask #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mask
);
    // Mask update: ones in wdata set or clear the matching bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask <= '0;
        else if (set_en) mask <= mask | wdata;
        else if (clr_en) mask <= mask & ~wdata;
    end

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (($past(wdata) & ~mask) == '0));
    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (($past(wdata) & mask) == '0));
    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask));
endmodule

// File: rtl/gpio_irq_status.sv
// gpio_irq_status: sticky event status, cleared by a status read.
// A hit in the read cycle wins over the clear so no event is lost.
module gpio_irq_status #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hit,
    input  logic             rd_clr,
    output logic [LINES-1:0] status
);
    // Status latch: clear on read, then OR in this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~{LINES{rd_clr}}) | hit;
    end

    // R12
    hit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(hit) & ~status) == '0));
    // R11
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((status & ~$past(hit)) == '0));
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(status) & ~status) == '0));
    // R11
    set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
// gpio_irq_bank: top of the bank interrupt detector. Decodes the register
// bus, registers read data, and combines status with mask into irq.
// Assumes at most one of bus_wr / bus_rd per cycle.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LINES-1:0]       pin_lvl,
    input  logic [LINES*EVT_W-1:0] evt_sel,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [LINES-1:0]       bus_wdata,
    output logic [LINES-1:0]       bus_rdata,
    output logic                   irq
);
    logic [LINES-1:0] hit;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] status_q;
    logic             sel_set, sel_clr, sel_mrd, sel_stat;

    // Address decode of the four register offsets.
    always_comb begin
        sel_set  = bus_addr == ADDR_W'(OFF_MASK_SET);
        sel_clr  = bus_addr == ADDR_W'(OFF_MASK_CLR);
        sel_mrd  = bus_addr == ADDR_W'(OFF_MASK_RD);
        sel_stat = bus_addr == ADDR_W'(OFF_STATUS);
    end

    gpio_evt_detect #(.LINES(LINES)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_lvl),
        .sel   (evt_sel),
        .hit   (hit)
    );

    gpio_irq_mask #(.LINES(LINES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && sel_set),
        .clr_en (bus_wr && sel_clr),
        .wdata  (bus_wdata),
        .mask   (mask_q)
    );

    gpio_irq_status #(.LINES(LINES)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .rd_clr (bus_rd && sel_stat),
        .status (status_q)
    );

    // Read data register: captures the addressed register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_rd && sel_mrd)  bus_rdata <= mask_q;
        else if (bus_rd && sel_stat) bus_rdata <= status_q;
        else if (bus_rd)             bus_rdata <= '0;
    end

    // Interrupt: any pending status bit that is also enabled.
    assign irq = |(status_q & mask_q);

    // R13
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0 && status_q != '0));
    // R11
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_stat) |=> (bus_rdata == $past(status_q)));
    // R10
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_mrd) |=> (bus_rdata == $past(mask_q)));
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
    localparam int N = 32;
    localparam logic [7:0] A_SET = 8'h20, A_CLR = 8'h24, A_MASK = 8'h28, A_STAT = 8'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   pins;
    logic [3*N-1:0] sel;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic irq;

    int checks = 0, errors = 0;
    logic [N-1:0] exp_q[$];
    string        req_q[$];
    logic         rd_pend = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .evt_sel(sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) check("scoreboard-underflow", bus_rdata, '0);
            else check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic rd(logic [7:0] a, logic [N-1:0] exp, string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic setpin(int k, logic v);
        @(negedge clk);
        pins[k] = v;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Line codes: 0 fall, 1 rise, 2 both, 3 low, 4 high, 5..7 reserved, rest rise.
        for (int i = 0; i < N; i++) sel[i*3 +: 3] = 3'd1;
        sel[0*3 +: 3] = 3'd0; sel[1*3 +: 3] = 3'd1; sel[2*3 +: 3] = 3'd2;
        sel[3*3 +: 3] = 3'd3; sel[4*3 +: 3] = 3'd4; sel[5*3 +: 3] = 3'd5;
        sel[6*3 +: 3] = 3'd6; sel[7*3 +: 3] = 3'd7;
        pins = 32'h0000_0009;           // line0 high, line3 high: no level event
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        check("R1 irq after reset", {31'b0, irq}, '0);
        rd(A_STAT, '0, "R1 no spurious status");
        rd(A_MASK, '0, "R1 mask reset");

        setpin(0, 1'b0);
        rd(A_STAT, 32'h1, "R2 falling edge");
        check("R13 masked event no irq", {31'b0, irq}, '0);
        rd(A_STAT, '0, "R11 cleared by read");

        setpin(1, 1'b1);
        rd(A_STAT, 32'h2, "R3 rising edge");
        setpin(1, 1'b0);
        rd(A_STAT, '0, "R3 falling ignored");

        setpin(2, 1'b1);
        rd(A_STAT, 32'h4, "R4 both rise");
        setpin(2, 1'b0);
        rd(A_STAT, 32'h4, "R4 both fall");

        for (int k = 5; k < 8; k++) setpin(k, 1'b1);
        for (int k = 5; k < 8; k++) setpin(k, 1'b0);
        rd(A_STAT, '0, "R7 reserved codes");

        setpin(4, 1'b1);
        rd(A_STAT, 32'h10, "R6 high level");
        rd(A_STAT, 32'h10, "R6 high level again");
        setpin(4, 1'b0);
        rd(A_STAT, 32'h10, "R6 last high latched");
        rd(A_STAT, '0, "R6 level gone");

        setpin(3, 1'b0);
        rd(A_STAT, 32'h8, "R5 low level");
        rd(A_STAT, 32'h8, "R5 re-set while low");
        setpin(3, 1'b1);
        rd(A_STAT, 32'h8, "R5 last low latched");
        rd(A_STAT, '0, "R5 level gone");

        wr(A_SET, 32'h9);
        rd(A_MASK, 32'h9, "R8 enable write");
        wr(A_SET, 32'h10);
        rd(A_MASK, 32'h19, "R8 enable keeps others");
        wr(A_CLR, 32'h1);
        rd(A_MASK, 32'h18, "R9 disable write");
        rd(8'h00, '0, "R10 unmapped read");
        check("R13 no pending no irq", {31'b0, irq}, '0);

        setpin(4, 1'b1);
        @(negedge clk);
        check("R13 masked-in event raises irq", {31'b0, irq}, 32'h1);
        setpin(4, 1'b0);
        rd(A_STAT, 32'h10, "R11 read with irq");
        check("R13 irq drops after read", {31'b0, irq}, '0);

        setpin(0, 1'b1);
        setpin(0, 1'b0);
        @(negedge clk);
        check("R13 unmasked line no irq", {31'b0, irq}, '0);
        rd(A_STAT, 32'h1, "R11 latched while unmasked");

        // R12: rising edge on line1 applied in the same cycle as a status read.
        @(negedge clk);
        pins[1] = 1'b1;
        bus_rd = 1'b1; bus_addr = A_STAT;
        exp_q.push_back('0); req_q.push_back("R12 same-cycle read excludes event");
        @(negedge clk);
        bus_rd = 1'b0;
        rd(A_STAT, 32'h2, "R12 event kept for next read");

        repeat (2) @(negedge clk);
        check("scoreboard drained", N'(exp_q.size()), '0);
        finish_run();
    end
endmodule